// File: doc/BRIEF.md
# Store Buffer with Total Store Ordering

This block sits between one in-order core's memory port and a single-port memory shared with other cores. The core hands it one request at a time: a load, a store or a fence, each with an address and, for stores, write data. Stores go into an in-order queue and leave for memory oldest first. Loads may go to memory ahead of older queued stores to other addresses. A load whose address matches a queued store is answered from the queue, from the most recent matching store, and does not touch memory. The result is total-store-order behaviour: the only reordering visible to other cores is a later load passing an earlier store.

A fence is held at the request port until the queue is empty. Every store before it is then in memory, so no load after it can overtake them. The request port follows valid/ready rules. The core holds `req_valid` and the request fields steady until a cycle where `req_ready` is high, and the request is taken on that edge. A store waits while the queue is full. A fence waits while the queue is not empty. A load that misses the queue waits until the memory grants it. Loads and fences answer with a single-cycle `rsp_valid` pulse one cycle after acceptance. This response has no back-pressure. Stores produce no response. The memory side is a request/grant pair: the memory returns read data in the same cycle it grants, and it performs a write on the granting edge.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty, `rsp_valid` is 0, and `mem_valid` stays 0 while no load is requested.
- R2: An accepted store produces no response. Queued stores are written to memory strictly in acceptance order, one per granted cycle, and a store is not visible in memory before its grant.
- R3: While DEPTH stores are queued, `req_ready` is 0 for a store request.
- R4: A load whose address matches any queued store returns the data of the youngest matching store, without a memory read.
- R5: A load that matches no queued store is sent to memory ahead of draining stores. It can complete while older stores to other addresses are still queued, and it returns the memory value.
- R6: A fence is accepted only when the queue is empty. Its response carries rdata 0. Op encoding: 00 load, 01 store, 1x fence.
- R7: `rsp_valid` is high for exactly one cycle, the cycle after an accepted load or fence.
- R8: A load that misses the queue is not accepted while the memory withholds its grant.
- R9: In a two-core store-then-load test (locations 0 and 1, both initially 0), each core reads its own store back as 1. With a fence between the store and the loads, the outcome where both cores read 0 from the other location never occurs. With memory writes held off, that outcome does occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request taken on this edge |
| req_op | input | 2 | 00 load, 01 store, 1x fence |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle response for a load or fence |
| rsp_rdata | output | DW | Load data (0 for fence) |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory grant |
| mem_we | output | 1 | 1 write (store drain), 0 read (load) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the grant cycle |

## Verification
The bench fills the queue to every level from empty to full with addresses that repeat. It then loads every address, so a design that forwards from the oldest match, or reads memory on a hit, returns stale data. It holds memory writes off to show that misses pass queued stores, and that a full queue and a non-empty queue refuse stores and fences; a design that lets either through would overrun the queue or break the fence. Two instances then run the store-then-load test at several relative offsets, with and without fences. A fence that fails to wait for the drain lets both cores read 0, and write reordering shows up in the recorded order of memory writes.

// File: rtl/tsob_pkg.sv
package tsob_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_STORE  = 2'b01,
    OP_FENCE  = 2'b10,
    OP_FENCE2 = 2'b11
  } op_e;
endpackage

// File: rtl/tsob_queue.sv
module tsob_queue #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [DEPTH-1:0] match;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign head_addr = slot_addr[head];
  assign head_data = slot_data[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail] <= push_addr;
      slot_data[tail] <= push_data;
    end
  end

  // per-slot occupancy and address compare
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PW:0] age;
    assign age = (PW+1)'((i + DEPTH - int'(head)) % DEPTH);
    assign match[i] = ({{(CW > PW+1 ? CW-PW-1 : 0){1'b0}}, age} < count) &&
                      (slot_addr[i] == look_addr);
  end

  // walk oldest to youngest so the last hit found is the youngest
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (match[(int'(head) + k) % DEPTH]) begin
        hit      = 1'b1;
        hit_data = slot_data[(int'(head) + k) % DEPTH];
      end
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_hit_needs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !empty);
endmodule

// File: rtl/tsob_port.sv
module tsob_port #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic          q_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ld_grant,
  output logic          drain_pop
);
  logic drain_req;

  // a waiting load owns the port; stores drain only when it is idle
  assign drain_req = !q_empty && !ld_req;
  assign mem_valid = ld_req || drain_req;
  assign mem_we    = drain_req;
  assign mem_addr  = ld_req ? ld_addr : head_addr;
  assign mem_wdata = head_data;
  assign ld_grant  = ld_req && mem_ready;
  assign drain_pop = drain_req && mem_ready;

  p_load_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !q_empty) |-> (mem_valid && !mem_we));
  p_write_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> !q_empty);
  p_grant_gates_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !mem_ready) |-> !ld_grant);
endmodule

// File: rtl/tsob_resp.sv
module tsob_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] data_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_rdata <= data_in;
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
  import tsob_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  op_e           op;
  logic          is_ld, is_st, is_fc;
  logic          q_empty, q_full, hit, ld_mem, ld_grant, drain_pop;
  logic          accept, push;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data, rsp_data;

  assign op    = op_e'(req_op);
  assign is_ld = (op == OP_LOAD);
  assign is_st = (op == OP_STORE);
  assign is_fc = (op == OP_FENCE) || (op == OP_FENCE2);

  assign ld_mem = req_valid && is_ld && !hit;

  always_comb begin
    if (is_ld)      req_ready = hit || ld_grant;
    else if (is_st) req_ready = !q_full;
    else            req_ready = q_empty;
  end

  assign accept   = req_valid && req_ready;
  assign push     = accept && is_st;
  assign rsp_data = !is_ld ? '0 : (hit ? hit_data : mem_rdata);

  tsob_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (drain_pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .empty     (q_empty),
    .full      (q_full),
    .look_addr (req_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  tsob_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_req    (ld_mem),
    .ld_addr   (req_addr),
    .q_empty   (q_empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ld_grant  (ld_grant),
    .drain_pop (drain_pop)
  );

  tsob_resp #(.DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (accept && !is_st),
    .data_in   (rsp_data),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  p_fence_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_fc) |-> q_empty);
  p_hit_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_ld && hit) |-> !(mem_valid && !mem_we));
  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && req_valid && is_st) |-> !req_ready);
  p_store_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !rsp_valid);
endmodule

// File: tb/sim_tso_store_buffer.sv
module sim_tso_store_buffer;
  localparam int AW = 3, DW = 8, DEPTH = 4, NW = 8;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, FC = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid [2], req_ready [2], rsp_valid [2];
  logic [1:0]    req_op    [2];
  logic [AW-1:0] req_addr  [2], mem_addr [2];
  logic [DW-1:0] req_wdata [2], rsp_rdata [2], mem_wdata [2], mem_rdata [2];
  logic          mem_valid [2], mem_ready [2], mem_we [2];

  tso_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_op(req_op[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .mem_valid(mem_valid[0]),
    .mem_ready(mem_ready[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
    .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata[0]));

  tso_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_op(req_op[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .mem_valid(mem_valid[1]),
    .mem_ready(mem_ready[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
    .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata[1]));

  // shared single-port memory with alternating priority
  logic [DW-1:0] shmem [NW];
  logic          prio, wblock, stall, elig0, elig1;
  logic [AW+DW-1:0] wlog [64];
  int            wcnt;

  always_comb begin
    elig0 = mem_valid[0] && !stall && !(wblock && mem_we[0]);
    elig1 = mem_valid[1] && !stall && !(wblock && mem_we[1]);
    mem_ready[0] = elig0 && (!elig1 || !prio);
    mem_ready[1] = elig1 && (!elig0 || prio);
    mem_rdata[0] = shmem[mem_addr[0]];
    mem_rdata[1] = shmem[mem_addr[1]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio <= 1'b0;
      wcnt <= 0;
      for (int i = 0; i < NW; i++) shmem[i] <= '0;
    end else begin
      prio <= ~prio;
      if (mem_ready[0] && mem_we[0]) begin
        shmem[mem_addr[0]] <= mem_wdata[0];
        if (wcnt < 64) wlog[wcnt] <= {mem_addr[0], mem_wdata[0]};
        wcnt <= wcnt + 1;
      end
      if (mem_ready[1] && mem_we[1]) shmem[mem_addr[1]] <= mem_wdata[1];
    end
  end

  int errors = 0, checks = 0;
  logic [DW-1:0] exp_mem [NW];
  logic [AW-1:0] mq_a [DEPTH];
  logic [DW-1:0] mq_d [DEPTH];
  int            mq_n;
  logic [DW-1:0] r_own [2], r_oth [2];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output logic got);
    @(negedge clk);
    req_valid[c] = 1'b1; req_op[c] = op; req_addr[c] = a; req_wdata[c] = d;
    #1;
    while (!req_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid[c] = 1'b0;
    got = rsp_valid[c];
    rd  = rsp_rdata[c];
  endtask

  // hold a request for n cycles without wanting it taken; report if it was ready
  task automatic probe(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                       input int n, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    req_valid[c] = 1'b1; req_op[c] = op; req_addr[c] = a; req_wdata[c] = 8'hEE;
    for (int i = 0; i < n; i++) begin
      #1;
      if (req_ready[c]) seen = 1'b1;
      @(negedge clk);
    end
    req_valid[c] = 1'b0;
  endtask

  task automatic do_reset();
    req_valid[0] = 1'b0; req_valid[1] = 1'b0;
    req_op[0] = LD; req_op[1] = LD;
    req_addr[0] = '0; req_addr[1] = '0; req_wdata[0] = '0; req_wdata[1] = '0;
    wblock = 1'b0; stall = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [DW-1:0] model_load(input logic [AW-1:0] a);
    logic [DW-1:0] v = exp_mem[a];
    for (int k = 0; k < DEPTH; k++)
      if (k < mq_n && mq_a[k] == a) v = mq_d[k];
    return v;
  endfunction

  task automatic run_core(input int c, input int f, input int dly);
    logic [DW-1:0] rd;
    logic got;
    repeat (dly) @(negedge clk);
    do_req(c, ST, AW'(c), 8'd1, rd, got);
    if (f != 0) do_req(c, FC, '0, '0, rd, got);
    do_req(c, LD, AW'(c), '0, rd, got);
    r_own[c] = rd;
    do_req(c, LD, AW'(1 - c), '0, rd, got);
    r_oth[c] = rd;
  endtask

  initial begin
    logic [DW-1:0] rd;
    logic got;
    bit seen;
    int base;
    do_reset();

    // R1: idle after reset
    @(negedge clk);
    check(rsp_valid[0] == 1'b0, "R1 rsp_valid", int'(rsp_valid[0]), 0);
    check(mem_valid[0] == 1'b0, "R1 mem_valid", int'(mem_valid[0]), 0);

    // preload location 5 through the second buffer
    do_req(1, ST, 3'd5, 8'd77, rd, got);
    do_req(1, FC, '0, '0, rd, got);

    // fill core 0 with writes held off
    wblock = 1'b1;
    do_req(0, ST, 3'd1, 8'd10, rd, got);
    check(got == 1'b0, "R2 store gives no response", int'(got), 0);
    do_req(0, ST, 3'd2, 8'd20, rd, got);
    do_req(0, ST, 3'd1, 8'd30, rd, got);
    do_req(0, ST, 3'd3, 8'd40, rd, got);
    check(shmem[1] == 8'd0, "R2 store not visible before grant", int'(shmem[1]), 0);

    probe(0, ST, 3'd4, 3, seen);
    check(seen == 1'b0, "R3 full refuses store", int'(seen), 0);
    probe(0, FC, 3'd0, 3, seen);
    check(seen == 1'b0, "R6 fence waits for empty queue", int'(seen), 0);

    do_req(0, LD, 3'd1, '0, rd, got);
    check(got && rd == 8'd30, "R4 youngest match forwarded", int'(rd), 30);
    @(negedge clk);
    check(rsp_valid[0] == 1'b0, "R7 response lasts one cycle", int'(rsp_valid[0]), 0);
    do_req(0, LD, 3'd2, '0, rd, got);
    check(rd == 8'd20, "R4 forward addr 2", int'(rd), 20);
    do_req(0, LD, 3'd5, '0, rd, got);
    check(got && rd == 8'd77, "R5 miss passes queued stores", int'(rd), 77);

    stall = 1'b1;
    probe(0, LD, 3'd6, 3, seen);
    check(seen == 1'b0, "R8 miss waits for grant", int'(seen), 0);
    stall = 1'b0;

    base = wcnt;
    wblock = 1'b0;
    do_req(0, FC, '0, '0, rd, got);
    check(got && rd == 8'd0, "R6 fence response rdata 0", int'(rd), 0);
    check(wcnt - base == 4, "R2 drained count", wcnt - base, 4);
    check(wlog[base]   == {3'd1, 8'd10}, "R2 order 0", int'(wlog[base]),   int'({3'd1, 8'd10}));
    check(wlog[base+1] == {3'd2, 8'd20}, "R2 order 1", int'(wlog[base+1]), int'({3'd2, 8'd20}));
    check(wlog[base+2] == {3'd1, 8'd30}, "R2 order 2", int'(wlog[base+2]), int'({3'd1, 8'd30}));
    check(wlog[base+3] == {3'd3, 8'd40}, "R2 order 3", int'(wlog[base+3]), int'({3'd3, 8'd40}));
    check(shmem[1] == 8'd30, "R2 final value", int'(shmem[1]), 30);

    // model of memory so far
    for (int i = 0; i < NW; i++) exp_mem[i] = '0;
    exp_mem[5] = 8'd77; exp_mem[1] = 8'd30; exp_mem[2] = 8'd20; exp_mem[3] = 8'd40;

    // sweep every fill level, repeated addresses, every load address
    for (int n = 0; n <= DEPTH; n++) begin
      wblock = 1'b1;
      mq_n = 0;
      for (int k = 0; k < n; k++) begin
        mq_a[k] = AW'((2 * k + n) % 4);
        mq_d[k] = DW'(16 * n + k + 1);
        do_req(0, ST, mq_a[k], mq_d[k], rd, got);
        mq_n++;
      end
      for (int a = 0; a < NW; a++) begin
        do_req(0, LD, AW'(a), '0, rd, got);
        check(got && rd == model_load(AW'(a)), "R4/R5 sweep load", int'(rd),
              int'(model_load(AW'(a))));
      end
      base = wcnt;
      wblock = 1'b0;
      do_req(0, FC, '0, '0, rd, got);
      check(wcnt - base == n, "R2 sweep drain count", wcnt - base, n);
      for (int k = 0; k < n; k++) begin
        check(wlog[base+k] == {mq_a[k], mq_d[k]}, "R2 sweep order",
              int'(wlog[base+k]), int'({mq_a[k], mq_d[k]}));
        exp_mem[mq_a[k]] = mq_d[k];
      end
      mq_n = 0;
      for (int a = 0; a < NW; a++)
        check(shmem[a] == exp_mem[a], "R2 sweep memory", int'(shmem[a]), int'(exp_mem[a]));
    end

    // two-core store-then-load test
    for (int f = 0; f < 2; f++) begin
      for (int wb = 0; wb < 2 - f; wb++) begin
        for (int d = 0; d < 4; d++) begin
          do_reset();
          wblock = (wb != 0);
          fork
            run_core(0, f, 0);
            run_core(1, f, d);
          join
          wblock = 1'b0;
          do_req(0, FC, '0, '0, rd, got);
          do_req(1, FC, '0, '0, rd, got);
          check(r_own[0] == 8'd1 && r_own[1] == 8'd1, "R9 own store read back",
                int'({r_own[0], r_own[1]}), int'({8'd1, 8'd1}));
          if (f != 0)
            check(!(r_oth[0] == 8'd0 && r_oth[1] == 8'd0), "R9 fence forbids 0,0",
                  int'({r_oth[0], r_oth[1]}), 1);
          if (wb != 0)
            check(r_oth[0] == 8'd0 && r_oth[1] == 8'd0, "R9 held writes give 0,0",
                  int'({r_oth[0], r_oth[1]}), 0);
          check(shmem[0] == 8'd1 && shmem[1] == 8'd1, "R9 final memory",
                int'({shmem[0], shmem[1]}), int'({8'd1, 8'd1}));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule